// File: doc/BRIEF.md
# Ordered Store Buffer with Fence Drain

This block sits between a core's retirement stage and its data cache. Each retired store is written into a small circular queue, and the core carries on executing while the stores wait for write permission from the coherence machinery. Stores leave the queue one at a time, oldest first, so other agents see them in the order the program issued them. The queue offers its oldest entry to the cache on a drain port. The cache takes that entry by returning a write grant that carries the same address.

Loads probe the queue in the same cycle they are presented. If the youngest queued store to the same word supplies every byte the load asks for, its data is forwarded. If that youngest store covers only some of the load's bytes, the load is told to stall, because bytes are never merged. A fence or a locked swap is raised as a request pulse. The block then stops accepting new stores, and it signals completion in the first cycle the queue holds nothing.

Top module: `stb_queue`

## Requirements
- R1: After reset the queue is empty: `drn_valid_o` is 0, `enq_ready_o` is 1, `fence_done_o` is 0, and a lookup reports neither hit nor stall.
- R2: The queue holds DEPTH (default 8) stores. `enq_ready_o` is 0 while all DEPTH slots are occupied, and a store offered in that state is not recorded.
- R3: The drain port always presents the oldest queued store (address, data, 4-bit byte mask, bit b enabling byte b, i.e. data bits 8b+7..8b). Stores leave strictly in the order they were accepted.
- R4: The head entry is removed only in a cycle where `drn_grant_i` is 1 and `drn_grant_addr_i` equals the head address. A grant that names any other address removes nothing.
- R5: A lookup matches entries whose address equals `ld_addr_i` and whose mask shares at least one byte with `ld_mask_i`. When the youngest such entry covers every requested byte, `ld_hit_o` is 1 and `ld_data_o` is that entry's data with the unrequested bytes forced to zero.
- R6: When the youngest matching entry lacks any requested byte, `ld_stall_o` is 1 and `ld_hit_o` is 0, even if an older entry would cover the load.
- R7: With no matching entry, or with `ld_valid_i` low, `ld_hit_o` and `ld_stall_o` are 0 and `ld_data_o` is 0.
- R8: `fence_done_o` is 1 in the cycle of the request if the queue is already empty. Otherwise it is 1 in the first cycle after the final store has left, and it lasts a single cycle.
- R9: From the request cycle until the cycle `fence_done_o` is 1, `enq_ready_o` is 0 and offered stores are not recorded.
- R10: While the head is not removed, the drain address, data and mask stay unchanged from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| enq_valid_i | input | 1 | A retired store is offered |
| enq_ready_o | output | 1 | The offered store is accepted this cycle |
| enq_addr_i | input | 32 | Word address of the store |
| enq_data_i | input | 32 | Store data |
| enq_mask_i | input | 4 | Byte enables of the store |
| ld_valid_i | input | 1 | A load lookup is presented |
| ld_addr_i | input | 32 | Word address of the load |
| ld_mask_i | input | 4 | Bytes the load requires |
| ld_hit_o | output | 1 | Full forwarding from the queue |
| ld_stall_o | output | 1 | Youngest match covers only part of the load |
| ld_data_o | output | 32 | Forwarded data, unrequested bytes zero |
| drn_valid_o | output | 1 | The queue holds a store for the cache |
| drn_addr_o | output | 32 | Address of the oldest store |
| drn_data_o | output | 32 | Data of the oldest store |
| drn_mask_o | output | 4 | Byte mask of the oldest store |
| drn_grant_i | input | 1 | Cache grants a write |
| drn_grant_addr_i | input | 32 | Address the grant applies to |
| fence_req_i | input | 1 | One-cycle fence or atomic request |
| fence_done_o | output | 1 | Queue empty, fence may complete |

## Verification
Lookup results are combinational on the registered queue contents, so they are due in the same cycle as the probe. A store accepted at a clock edge becomes visible to lookups and to the drain port only from the next cycle. A granted head leaves at the edge of the grant cycle. Fence completion comes in the request cycle when the queue is empty, or otherwise in the cycle after the last removing edge. The bench drives every input on the falling edge and samples one nanosecond later, before the next rising edge, so each comparison sees exactly the state those counts predict.

// File: rtl/stb_pkg.sv
package stb_pkg;
    localparam int unsigned STB_AW   = 32;
    localparam int unsigned STB_DW   = 32;
    localparam int unsigned STB_BE_W = STB_DW / 8;

    typedef struct packed {
        logic [STB_AW-1:0]   addr;
        logic [STB_DW-1:0]   data;
        logic [STB_BE_W-1:0] mask;
    } stb_ent_t;
endpackage

// File: rtl/stb_fwd.sv
// Load probe: scans live entries oldest to youngest; the last match wins.
module stb_fwd
    import stb_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  stb_ent_t [DEPTH-1:0]         ents_i,
    input  logic [$clog2(DEPTH)-1:0]     head_i,
    input  logic [$clog2(DEPTH):0]       cnt_i,
    input  logic                         ld_valid_i,
    input  logic [STB_AW-1:0]            ld_addr_i,
    input  logic [STB_BE_W-1:0]          ld_mask_i,
    output logic                         hit_o,
    output logic                         stall_o,
    output logic [STB_DW-1:0]            data_o
);
    localparam int unsigned PW = $clog2(DEPTH);
    localparam int unsigned CW = PW + 1;

    logic [PW-1:0]       idx;
    logic                found;
    logic                covers;
    logic [STB_DW-1:0]   sel_data;
    logic [STB_DW-1:0]   byte_sel;

    always_comb begin
        idx      = head_i;
        found    = 1'b0;
        covers   = 1'b0;
        sel_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (CW'(k) < cnt_i) begin
                idx = head_i + PW'(k);
                if ((ents_i[idx].addr == ld_addr_i) &&
                    ((ents_i[idx].mask & ld_mask_i) != '0)) begin
                    found    = 1'b1;
                    covers   = ((ld_mask_i & ~ents_i[idx].mask) == '0);
                    sel_data = ents_i[idx].data;
                end
            end
        end
    end

    always_comb begin
        for (int b = 0; b < STB_BE_W; b++) begin
            byte_sel[b*8 +: 8] = {8{ld_mask_i[b]}};
        end
    end

    assign hit_o   = ld_valid_i && found && covers;
    assign stall_o = ld_valid_i && found && !covers;
    assign data_o  = hit_o ? (sel_data & byte_sel) : '0;
endmodule

// File: rtl/stb_fence.sv
// Fence/atomic tracker: holds a pending flag until the queue is seen empty.
module stb_fence (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    input  logic empty_i,
    output logic block_o,
    output logic done_o
);
    typedef struct packed {
        logic pend;
    } fence_st_t;

    fence_st_t st_d, st_q;
    logic      active;

    assign active  = req_i | st_q.pend;
    assign block_o = active;
    assign done_o  = active & empty_i;

    always_comb begin
        st_d      = st_q;
        st_d.pend = active & ~done_o;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/stb_queue.sv
// Ordered store buffer: circular queue, head-only drain, same-cycle load probe.
module stb_queue
    import stb_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 enq_valid_i,
    output logic                 enq_ready_o,
    input  logic [STB_AW-1:0]    enq_addr_i,
    input  logic [STB_DW-1:0]    enq_data_i,
    input  logic [STB_BE_W-1:0]  enq_mask_i,
    input  logic                 ld_valid_i,
    input  logic [STB_AW-1:0]    ld_addr_i,
    input  logic [STB_BE_W-1:0]  ld_mask_i,
    output logic                 ld_hit_o,
    output logic                 ld_stall_o,
    output logic [STB_DW-1:0]    ld_data_o,
    output logic                 drn_valid_o,
    output logic [STB_AW-1:0]    drn_addr_o,
    output logic [STB_DW-1:0]    drn_data_o,
    output logic [STB_BE_W-1:0]  drn_mask_o,
    input  logic                 drn_grant_i,
    input  logic [STB_AW-1:0]    drn_grant_addr_i,
    input  logic                 fence_req_i,
    output logic                 fence_done_o
);
    localparam int unsigned PW = $clog2(DEPTH);
    localparam int unsigned CW = PW + 1;

    typedef struct packed {
        logic [PW-1:0] head;
        logic [PW-1:0] tail;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t                  st_d, st_q;
    stb_ent_t [DEPTH-1:0]  ent_d, ent_q;
    stb_ent_t              head_ent;
    logic                  fence_block;
    logic                  q_empty;
    logic                  do_push;
    logic                  do_pop;

    assign q_empty  = (st_q.cnt == '0);
    assign head_ent = ent_q[st_q.head];

    stb_fence u_fence (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .req_i   (fence_req_i),
        .empty_i (q_empty),
        .block_o (fence_block),
        .done_o  (fence_done_o)
    );

    stb_fwd #(.DEPTH(DEPTH)) u_fwd (
        .ents_i     (ent_q),
        .head_i     (st_q.head),
        .cnt_i      (st_q.cnt),
        .ld_valid_i (ld_valid_i),
        .ld_addr_i  (ld_addr_i),
        .ld_mask_i  (ld_mask_i),
        .hit_o      (ld_hit_o),
        .stall_o    (ld_stall_o),
        .data_o     (ld_data_o)
    );

    assign enq_ready_o = (st_q.cnt != CW'(DEPTH)) && !fence_block;
    assign do_push     = enq_valid_i && enq_ready_o;

    assign drn_valid_o = !q_empty;
    assign drn_addr_o  = head_ent.addr;
    assign drn_data_o  = head_ent.data;
    assign drn_mask_o  = head_ent.mask;
    assign do_pop      = drn_valid_o && drn_grant_i &&
                         (drn_grant_addr_i == head_ent.addr);

    always_comb begin
        st_d  = st_q;
        ent_d = ent_q;
        if (do_push) begin
            ent_d[st_q.tail].addr = enq_addr_i;
            ent_d[st_q.tail].data = enq_data_i;
            ent_d[st_q.tail].mask = enq_mask_i;
            st_d.tail             = st_q.tail + PW'(1);
        end
        if (do_pop) begin
            st_d.head = st_q.head + PW'(1);
        end
        st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q  <= '0;
            ent_q <= '0;
        end else begin
            st_q  <= st_d;
            ent_q <= ent_d;
        end
    end
endmodule

// File: rtl/stb_queue_chk.sv
module stb_queue_chk
    import stb_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input logic                          clk_i,
    input logic                          rst_ni,
    input logic                          enq_valid_i,
    input logic                          enq_ready_o,
    input logic                          ld_hit_o,
    input logic                          ld_stall_o,
    input logic [STB_DW-1:0]             ld_data_o,
    input logic                          drn_valid_o,
    input logic [STB_AW-1:0]             drn_addr_o,
    input logic [STB_DW-1:0]             drn_data_o,
    input logic [STB_BE_W-1:0]           drn_mask_o,
    input logic                          drn_grant_i,
    input logic [STB_AW-1:0]             drn_grant_addr_i,
    input logic                          fence_req_i,
    input logic                          fence_done_o,
    input logic [$clog2(DEPTH):0]        occ_i
);
    localparam int unsigned CW = $clog2(DEPTH) + 1;

    logic granted;
    assign granted = drn_grant_i && (drn_grant_addr_i == drn_addr_o);

    p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (occ_i == CW'(DEPTH)) |-> !enq_ready_o);

    p_pop_needs_grant_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drn_valid_o && !granted && !(enq_valid_i && enq_ready_o)) |=> (occ_i == $past(occ_i)));

    p_hold_head_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drn_valid_o && !granted) |=>
            (drn_valid_o && $stable(drn_addr_o) && $stable(drn_data_o) && $stable(drn_mask_o)));

    p_fence_block_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fence_req_i |-> !enq_ready_o);

    p_pend_block_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fence_req_i && !fence_done_o) |=> !enq_ready_o);

    p_done_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fence_done_o |-> (occ_i == '0));

    p_fwd_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ld_hit_o && ld_stall_o));

    p_fwd_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ld_hit_o |-> (ld_data_o == '0));
endmodule

bind stb_queue stb_queue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .enq_valid_i      (enq_valid_i),
    .enq_ready_o      (enq_ready_o),
    .ld_hit_o         (ld_hit_o),
    .ld_stall_o       (ld_stall_o),
    .ld_data_o        (ld_data_o),
    .drn_valid_o      (drn_valid_o),
    .drn_addr_o       (drn_addr_o),
    .drn_data_o       (drn_data_o),
    .drn_mask_o       (drn_mask_o),
    .drn_grant_i      (drn_grant_i),
    .drn_grant_addr_i (drn_grant_addr_i),
    .fence_req_i      (fence_req_i),
    .fence_done_o     (fence_done_o),
    .occ_i            (st_q.cnt)
);

// File: tb/stb_queue_tb.sv
`timescale 1ns/1ps
module stb_queue_tb_top;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enq_valid = 1'b0;
    logic        enq_ready;
    logic [31:0] enq_addr = '0;
    logic [31:0] enq_data = '0;
    logic [3:0]  enq_mask = '0;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_addr = '0;
    logic [3:0]  ld_mask = '0;
    logic        ld_hit, ld_stall;
    logic [31:0] ld_data;
    logic        drn_valid;
    logic [31:0] drn_addr, drn_data;
    logic [3:0]  drn_mask;
    logic        drn_grant = 1'b0;
    logic [31:0] drn_grant_addr = '0;
    logic        fence_req = 1'b0;
    logic        fence_done;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    logic [31:0] qa[$];
    logic [31:0] qd[$];
    logic [3:0]  qm[$];

    always #4 clk = ~clk;

    stb_queue #(.DEPTH(DEPTH)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .enq_valid_i(enq_valid), .enq_ready_o(enq_ready),
        .enq_addr_i(enq_addr), .enq_data_i(enq_data), .enq_mask_i(enq_mask),
        .ld_valid_i(ld_valid), .ld_addr_i(ld_addr), .ld_mask_i(ld_mask),
        .ld_hit_o(ld_hit), .ld_stall_o(ld_stall), .ld_data_o(ld_data),
        .drn_valid_o(drn_valid), .drn_addr_o(drn_addr), .drn_data_o(drn_data),
        .drn_mask_o(drn_mask), .drn_grant_i(drn_grant), .drn_grant_addr_i(drn_grant_addr),
        .fence_req_i(fence_req), .fence_done_o(fence_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] bytes_of(input logic [3:0] m);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[b*8 +: 8] = {8{m[b]}};
        return r;
    endfunction

    task automatic push(input logic [31:0] a, input logic [31:0] d, input logic [3:0] m);
        bit exp_rdy;
        @(negedge clk);
        enq_valid = 1'b1; enq_addr = a; enq_data = d; enq_mask = m;
        #1;
        exp_rdy = (qa.size() < DEPTH);
        check(enq_ready == exp_rdy, "R2", "enq_ready", {31'd0, enq_ready}, {31'd0, exp_rdy});
        if (exp_rdy) begin qa.push_back(a); qd.push_back(d); qm.push_back(m); end
        @(posedge clk); #1;
        enq_valid = 1'b0;
    endtask

    task automatic pop_head();
        @(negedge clk); #1;
        check(drn_valid == 1'b1, "R3", "drn_valid", {31'd0, drn_valid}, 32'd1);
        check(drn_addr == qa[0], "R3", "drain addr order", drn_addr, qa[0]);
        check(drn_data == qd[0], "R3", "drain data order", drn_data, qd[0]);
        check(drn_mask == qm[0], "R3", "drain mask order", {28'd0, drn_mask}, {28'd0, qm[0]});
        drn_grant = 1'b1; drn_grant_addr = qa[0];
        @(posedge clk); #1;
        drn_grant = 1'b0;
        void'(qa.pop_front()); void'(qd.pop_front()); void'(qm.pop_front());
    endtask

    task automatic lookup(input logic [31:0] a, input logic [3:0] m, input string req);
        bit          e_hit, e_stall, found;
        logic [31:0] e_data;
        found = 1'b0; e_hit = 1'b0; e_stall = 1'b0; e_data = '0;
        for (int i = qa.size() - 1; i >= 0; i--) begin
            if (!found && qa[i] == a && (qm[i] & m) != 4'd0) begin
                found = 1'b1;
                if ((m & ~qm[i]) == 4'd0) begin e_hit = 1'b1; e_data = qd[i] & bytes_of(m); end
                else e_stall = 1'b1;
            end
        end
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = a; ld_mask = m;
        #1;
        check(ld_hit == e_hit, req, "ld_hit", {31'd0, ld_hit}, {31'd0, e_hit});
        check(ld_stall == e_stall, req, "ld_stall", {31'd0, ld_stall}, {31'd0, e_stall});
        check(ld_data == e_data, req, "ld_data", ld_data, e_data);
        ld_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        check(drn_valid == 1'b0, "R1", "drn_valid", {31'd0, drn_valid}, 32'd0);
        check(enq_ready == 1'b1, "R1", "enq_ready", {31'd0, enq_ready}, 32'd1);
        check(fence_done == 1'b0, "R1", "fence_done", {31'd0, fence_done}, 32'd0);
        lookup(32'h0, 4'hF, "R1");

        // R2 fill to capacity, then one store that must be refused
        for (int i = 0; i < DEPTH; i++)
            push(32'h1000 + 32'(i) * 4, 32'hA500_0000 | 32'(i * 7), 4'(i % 15 + 1));
        push(32'h1000, 32'hDEAD_BEEF, 4'hF);
        for (int i = 0; i < DEPTH; i++)
            lookup(32'h1000 + 32'(i) * 4, 4'hF, "R5");
        lookup(32'h2000, 4'hF, "R7");

        // R4 / R10 grant for another address removes nothing, head holds
        @(negedge clk);
        drn_grant = 1'b1; drn_grant_addr = qa[0] ^ 32'h4;
        @(posedge clk); #1;
        drn_grant = 1'b0;
        @(negedge clk); #1;
        check(drn_addr == qa[0], "R4", "head addr after foreign grant", drn_addr, qa[0]);
        check(drn_data == qd[0], "R10", "head data stable", drn_data, qd[0]);
        check(drn_mask == qm[0], "R10", "head mask stable", {28'd0, drn_mask}, {28'd0, qm[0]});

        // R3 drain in order; refused store must not appear
        for (int i = 0; i < DEPTH; i++) pop_head();
        @(negedge clk); #1;
        check(drn_valid == 1'b0, "R2", "refused store absent", {31'd0, drn_valid}, 32'd0);

        // R5 youngest wins, R6 partial youngest stalls
        push(32'h300, 32'h1111_1111, 4'hF);
        push(32'h300, 32'h2222_2222, 4'hF);
        lookup(32'h300, 4'hF, "R5");
        lookup(32'h300, 4'h6, "R5");
        push(32'h300, 32'h3333_3333, 4'h1);
        lookup(32'h300, 4'hF, "R6");
        lookup(32'h300, 4'h1, "R5");
        lookup(32'h300, 4'h2, "R5");
        lookup(32'h304, 4'hF, "R7");
        for (int i = 0; i < 3; i++) pop_head();

        // R8 / R9 fence with three queued stores
        for (int i = 0; i < 3; i++) push(32'h500 + 32'(i) * 4, 32'h5000_0000 + 32'(i), 4'hF);
        @(negedge clk);
        fence_req = 1'b1; enq_valid = 1'b1; enq_addr = 32'h900; enq_data = 32'h9; enq_mask = 4'hF;
        #1;
        check(enq_ready == 1'b0, "R9", "ready in request cycle", {31'd0, enq_ready}, 32'd0);
        check(fence_done == 1'b0, "R8", "done while busy", {31'd0, fence_done}, 32'd0);
        @(posedge clk); #1;
        fence_req = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            check(enq_ready == 1'b0, "R9", "ready while pending", {31'd0, enq_ready}, 32'd0);
            check(fence_done == 1'b0, "R8", "done before empty", {31'd0, fence_done}, 32'd0);
            check(drn_addr == qa[0], "R3", "fence drain order", drn_addr, qa[0]);
            drn_grant = 1'b1; drn_grant_addr = qa[0];
            @(posedge clk); #1;
            drn_grant = 1'b0;
            void'(qa.pop_front()); void'(qd.pop_front()); void'(qm.pop_front());
        end
        @(negedge clk); #1;
        check(fence_done == 1'b1, "R8", "done first empty cycle", {31'd0, fence_done}, 32'd1);
        check(drn_valid == 1'b0, "R9", "store during fence dropped", {31'd0, drn_valid}, 32'd0);
        enq_valid = 1'b0;
        @(negedge clk); #1;
        check(fence_done == 1'b0, "R8", "done single cycle", {31'd0, fence_done}, 32'd0);
        check(enq_ready == 1'b1, "R9", "ready after fence", {31'd0, enq_ready}, 32'd1);

        // R8 fence on an empty queue completes at once
        @(negedge clk);
        fence_req = 1'b1;
        #1;
        check(fence_done == 1'b1, "R8", "done same cycle when empty", {31'd0, fence_done}, 32'd1);
        @(posedge clk); #1;
        fence_req = 1'b0;
        @(negedge clk); #1;
        check(enq_ready == 1'b1, "R9", "no lingering pend", {31'd0, enq_ready}, 32'd1);

        // Exhaustive mask sweep: R5 full cover, R6 partial, R7 disjoint
        for (int em = 1; em < 16; em++) begin
            for (int lm = 1; lm < 16; lm++) begin
                push(32'h4000, 32'h0102_0304 ^ 32'(em * 16 + lm), 4'(em));
                if ((lm & ~em) == 0) lookup(32'h4000, 4'(lm), "R5");
                else if ((lm & em) != 0) lookup(32'h4000, 4'(lm), "R6");
                else lookup(32'h4000, 4'(lm), "R7");
                pop_head();
            end
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule